// File: doc/BRIEF.md
# DMA Channel Block Reload Controller

This block sequences the block transfers of one DMA channel. It holds a working set of three counters: an A address, a B address and a byte count. Each beat that the channel acknowledges moves both addresses forward by one and takes one off the count. A shadow set of the same three registers holds the parameters for the next block. A valid flag marks the shadow set as armed, and only a write to the shadow count register sets that flag.

When the last byte of a block is acknowledged, the channel flags terminal count. What happens next depends on the mode and the valid flag:

- **Double-buffer mode.** If software armed the shadow set in time, the channel chains into the next block on the following cycle. If it did not, the channel stops with an overrun flag.
- **Auto-initialize mode.** The channel reloads from the shadow set at every terminal count and keeps refilling the same region with no software action.
- **Flyby (direct) mode.** The B address is neither advanced nor reloaded.

Software reaches every register through one word-wide write/read port. The terminal-count and overrun conditions drive two level interrupt outputs. The register data width must be at least the address and count widths.

Top module: `dma_block_reload`

## Requirements
- R1: After reset, every register reads 0, the acknowledge output is low even with a request pending, and both interrupt outputs are low.
- R2: The register offsets are: control 0, status 1, working A 2, working B 3, working count 4, shadow A 5, shadow B 6, shadow count 7. All of them read back over the read port, zero-extended.
- R3: Control bit 0 enables the channel, bit 1 selects auto-initialize, bit 2 enables the terminal-count interrupt, bit 3 enables the overrun interrupt and bit 4 selects indirect (B address in use) mode. A write that sets bit 0 while the channel is disabled latches all five bits and sets the active flag. A write while enabled changes only bit 0. Clearing bit 0 clears the active flag and stops acknowledges.
- R4: While the channel is active and the working count is nonzero, the acknowledge output follows the request input. Each acknowledged beat decrements the count and increments A. It increments B only in indirect mode.
- R5: Writes to the working registers are ignored while the active flag is set.
- R6: Status bits are: bit 0 valid, bit 1 terminal count, bit 2 overrun, bit 3 active. A shadow-count write sets valid and a shadow A or B write does not. Writing 1 to status bit 0 clears valid, and a shadow-count write in the same cycle wins over that clear.
- R7: The beat that takes the count from 1 to 0 sets terminal count. The terminal-count interrupt output equals terminal count AND control bit 2.
- R8: In double-buffer mode, a last beat with valid set copies the shadow set into the working set and clears valid. The channel stays active and acknowledges the next beat in the following cycle.
- R9: In double-buffer mode, a last beat with valid clear sets overrun, clears active and leaves the count at 0. The overrun interrupt output equals overrun AND control bit 3.
- R10: In auto-initialize mode every last beat reloads the working set from the shadow set whatever valid holds. It leaves valid unchanged, sets no overrun and keeps the channel active.
- R11: In flyby mode (control bit 4 clear) a reload does not copy shadow B into working B.
- R12: A shadow-count write in the same cycle as a last beat comes too late for that block. The old valid value decides between chaining and overrun, and valid is set afterwards.
- R13: Terminal count and overrun clear when 1 is written to their status bit. A flag being set in the same cycle as such a write stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset for write and read |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data for regAddr (combinational) |
| xferReq | input | 1 | Transfer request, one beat per acknowledged cycle |
| xferAck | output | 1 | Transfer acknowledge; a beat happens when request and acknowledge are both high |
| busAddrA | output | ADDR_W | Working A address of the current beat |
| busAddrB | output | ADDR_W | Working B address of the current beat |
| irqTc | output | 1 | Terminal-count interrupt level |
| irqOvr | output | 1 | Overrun interrupt level |

## Verification
The assertions check several relations on every cycle:
- each non-final beat takes exactly one off the count;
- a reload places the shadow values in the working set;
- a flyby reload leaves B untouched;
- valid only rises after a shadow-count write;
- chaining keeps the channel active while a stop drops it with overrun set;
- the channel is never active while disabled.

Only the bench scenarios can show the effects that build up over a sequence of operations. These include the full double-buffer sequence from arming through chaining to overrun, the auto-initialize refill with valid clear, control bits ignored while enabled, and the late shadow write that still leads to overrun. They also include a terminal-count flag surviving a clear in the same cycle.

// File: rtl/dma_reload_pkg.sv
package dma_reload_pkg;

  localparam int REG_AW    = 3;
  localparam int CTRL_BITS = 5;

  // Register offsets
  typedef enum logic [REG_AW-1:0] {
    REG_CTRL    = 3'd0,
    REG_STAT    = 3'd1,
    REG_CUR_A   = 3'd2,
    REG_CUR_B   = 3'd3,
    REG_CUR_CNT = 3'd4,
    REG_RLD_A   = 3'd5,
    REG_RLD_B   = 3'd6,
    REG_RLD_CNT = 3'd7
  } regSel_e;

  // Control bit positions
  localparam int CTRL_EN    = 0;
  localparam int CTRL_AUTO  = 1;
  localparam int CTRL_TCIE  = 2;
  localparam int CTRL_OVRIE = 3;
  localparam int CTRL_INDIR = 4;

  // Status bit positions
  localparam int ST_VLD = 0;
  localparam int ST_TC  = 1;
  localparam int ST_OVR = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrCurA;
    logic wrCurB;
    logic wrCurCnt;
    logic wrRldA;
    logic wrRldB;
    logic wrRldCnt;
    logic beat;
    logic incB;
    logic load;
    logic loadB;
  } dpStrobe_t;

  typedef struct packed {
    logic enable;
    logic autoInit;
    logic tcIrqEn;
    logic ovrIrqEn;
    logic indirect;
  } ctrl_t;

endpackage

// File: rtl/dma_reload_datapath.sv
module dma_reload_datapath
  import dma_reload_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [ADDR_W-1:0] curA,
  output logic [ADDR_W-1:0] curB,
  output logic [CNT_W-1:0]  curCnt,
  output logic [ADDR_W-1:0] rldA,
  output logic [ADDR_W-1:0] rldB,
  output logic [CNT_W-1:0]  rldCnt,
  output logic              cntIsZero,
  output logic              cntIsOne
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  logic [ADDR_W-1:0] wrAddr;
  logic [CNT_W-1:0]  wrCnt;

  assign wrAddr    = wrData[ADDR_W-1:0];
  assign wrCnt     = wrData[CNT_W-1:0];
  assign cntIsZero = (curCnt == '0);
  assign cntIsOne  = (curCnt == CNT_ONE);

  // Working A address
  always_ff @(posedge clk) begin
    if (!rstN)              curA <= '0;
    else if (strobe.load)   curA <= rldA;
    else if (strobe.beat)   curA <= curA + ADDR_ONE;
    else if (strobe.wrCurA) curA <= wrAddr;
  end

  // Working B address: only touched in indirect mode
  always_ff @(posedge clk) begin
    if (!rstN)                          curB <= '0;
    else if (strobe.load && strobe.loadB) curB <= rldB;
    else if (strobe.beat && strobe.incB)  curB <= curB + ADDR_ONE;
    else if (strobe.wrCurB)               curB <= wrAddr;
  end

  // Working byte count
  always_ff @(posedge clk) begin
    if (!rstN)                curCnt <= '0;
    else if (strobe.load)     curCnt <= rldCnt;
    else if (strobe.beat)     curCnt <= curCnt - CNT_ONE;
    else if (strobe.wrCurCnt) curCnt <= wrCnt;
  end

  // Shadow reload set
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rldA   <= '0;
      rldB   <= '0;
      rldCnt <= '0;
    end else begin
      if (strobe.wrRldA)   rldA   <= wrAddr;
      if (strobe.wrRldB)   rldB   <= wrAddr;
      if (strobe.wrRldCnt) rldCnt <= wrCnt;
    end
  end

  // R4: a beat that does not reload takes exactly one off the count
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.beat && !strobe.load) |=> (curCnt == $past(curCnt) - CNT_ONE));

  // R8: a reload places the previous shadow values in the working set
  a_r8_load_copies: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (curCnt == $past(rldCnt) && curA == $past(rldA)));

  // R11: a flyby reload leaves B where it was
  a_r11_b_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.loadB) |=> (curB == $past(curB)));

endmodule

// File: rtl/dma_reload_control.sv
module dma_reload_control
  import dma_reload_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic [CTRL_BITS-1:0] wrBits,
  input  logic                 xferReq,
  input  logic                 cntIsZero,
  input  logic                 cntIsOne,
  output dpStrobe_t            strobe,
  output ctrl_t                ctrl,
  output logic                 vld,
  output logic                 tc,
  output logic                 ovr,
  output logic                 act,
  output logic                 xferAck,
  output logic                 irqTc,
  output logic                 irqOvr
);

  logic wrCtrl, wrStat, wrRldCnt;
  logic enRise, enFall;
  logic beat, lastBeat, chain, stop;

  assign wrCtrl   = regWrEn && (regAddr == REG_CTRL);
  assign wrStat   = regWrEn && (regAddr == REG_STAT);
  assign wrRldCnt = regWrEn && (regAddr == REG_RLD_CNT);

  assign enRise = wrCtrl &&  wrBits[CTRL_EN] && !ctrl.enable;
  assign enFall = wrCtrl && !wrBits[CTRL_EN] &&  ctrl.enable;

  assign beat     = act && xferReq && !cntIsZero;
  assign lastBeat = beat && cntIsOne;
  assign chain    = lastBeat && (ctrl.autoInit || vld);
  assign stop     = lastBeat && !chain;

  // Control: full write while disabled, enable bit only while enabled
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrl <= '0;
    end else if (wrCtrl) begin
      if (!ctrl.enable) begin
        ctrl.enable   <= wrBits[CTRL_EN];
        ctrl.autoInit <= wrBits[CTRL_AUTO];
        ctrl.tcIrqEn  <= wrBits[CTRL_TCIE];
        ctrl.ovrIrqEn <= wrBits[CTRL_OVRIE];
        ctrl.indirect <= wrBits[CTRL_INDIR];
      end else begin
        ctrl.enable   <= wrBits[CTRL_EN];
      end
    end
  end

  // Active flag and status flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      act <= 1'b0;
      vld <= 1'b0;
      tc  <= 1'b0;
      ovr <= 1'b0;
    end else begin
      if (enRise)              act <= 1'b1;
      else if (enFall || stop) act <= 1'b0;

      // A shadow-count write lands after the terminal decision
      if (wrRldCnt)                        vld <= 1'b1;
      else if (chain && !ctrl.autoInit)    vld <= 1'b0;
      else if (wrStat && wrBits[ST_VLD])   vld <= 1'b0;

      if (lastBeat)                       tc <= 1'b1;
      else if (wrStat && wrBits[ST_TC])   tc <= 1'b0;

      if (stop)                           ovr <= 1'b1;
      else if (wrStat && wrBits[ST_OVR])  ovr <= 1'b0;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.wrCurA   = regWrEn && (regAddr == REG_CUR_A)   && !act;
    strobe.wrCurB   = regWrEn && (regAddr == REG_CUR_B)   && !act;
    strobe.wrCurCnt = regWrEn && (regAddr == REG_CUR_CNT) && !act;
    strobe.wrRldA   = regWrEn && (regAddr == REG_RLD_A);
    strobe.wrRldB   = regWrEn && (regAddr == REG_RLD_B);
    strobe.wrRldCnt = wrRldCnt;
    strobe.beat     = beat;
    strobe.incB     = ctrl.indirect;
    strobe.load     = chain;
    strobe.loadB    = chain && ctrl.indirect;
  end

  assign xferAck = beat;
  assign irqTc   = tc  && ctrl.tcIrqEn;
  assign irqOvr  = ovr && ctrl.ovrIrqEn;

  // R6: valid rises only after a shadow-count write
  a_r6_vld_source: assert property (@(posedge clk) disable iff (!rstN)
    (vld && !$past(vld)) |-> $past(regWrEn && regAddr == REG_RLD_CNT));

  // R9: a stop leaves the channel idle with overrun set
  a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    stop |=> (!act && ovr));

  // R8: chaining keeps the channel running with terminal count flagged
  a_r8_chain_runs: assert property (@(posedge clk) disable iff (!rstN)
    chain |=> (act && tc));

  // R3: the channel is never active while disabled
  a_r3_act_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    act |-> ctrl.enable);

  // R10: an auto-initialize terminal count never overruns
  a_r10_auto_no_ovr: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && ctrl.autoInit) |=> (act && $stable(ovr)));

endmodule

// File: rtl/dma_block_reload.sv
module dma_block_reload
  import dma_reload_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              xferReq,
  output logic              xferAck,
  output logic [ADDR_W-1:0] busAddrA,
  output logic [ADDR_W-1:0] busAddrB,
  output logic              irqTc,
  output logic              irqOvr
);

  dpStrobe_t         strobe;
  ctrl_t             ctrl;
  logic              vld, tc, ovr, act;
  logic              cntIsZero, cntIsOne;
  logic [ADDR_W-1:0] curA, curB, rldA, rldB;
  logic [CNT_W-1:0]  curCnt, rldCnt;
  logic [CTRL_BITS-1:0] ctrlRd;
  logic [3:0]        statRd;

  dma_reload_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .wrBits    (regWrData[CTRL_BITS-1:0]),
    .xferReq   (xferReq),
    .cntIsZero (cntIsZero),
    .cntIsOne  (cntIsOne),
    .strobe    (strobe),
    .ctrl      (ctrl),
    .vld       (vld),
    .tc        (tc),
    .ovr       (ovr),
    .act       (act),
    .xferAck   (xferAck),
    .irqTc     (irqTc),
    .irqOvr    (irqOvr)
  );

  dma_reload_datapath #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (regWrData),
    .curA      (curA),
    .curB      (curB),
    .curCnt    (curCnt),
    .rldA      (rldA),
    .rldB      (rldB),
    .rldCnt    (rldCnt),
    .cntIsZero (cntIsZero),
    .cntIsOne  (cntIsOne)
  );

  assign ctrlRd = {ctrl.indirect, ctrl.ovrIrqEn, ctrl.tcIrqEn, ctrl.autoInit, ctrl.enable};
  assign statRd = {act, ovr, tc, vld};

  always_comb begin
    unique case (regSel_e'(regAddr))
      REG_CTRL:    regRdData = DATA_W'(ctrlRd);
      REG_STAT:    regRdData = DATA_W'(statRd);
      REG_CUR_A:   regRdData = DATA_W'(curA);
      REG_CUR_B:   regRdData = DATA_W'(curB);
      REG_CUR_CNT: regRdData = DATA_W'(curCnt);
      REG_RLD_A:   regRdData = DATA_W'(rldA);
      REG_RLD_B:   regRdData = DATA_W'(rldB);
      REG_RLD_CNT: regRdData = DATA_W'(rldCnt);
      default:     regRdData = '0;
    endcase
  end

  assign busAddrA = curA;
  assign busAddrB = curB;

endmodule

// File: tb/dma_block_reload_tb.sv
`timescale 1ns/1ps
module dma_block_reload_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [15:0] regWrData = 16'h0;
  logic [15:0] regRdData;
  logic        xferReq = 1'b0;
  logic        xferAck;
  logic [15:0] busAddrA, busAddrB;
  logic        irqTc, irqOvr;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  dma_block_reload u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .xferReq   (xferReq),
    .xferAck   (xferAck),
    .busAddrA  (busAddrA),
    .busAddrB  (busAddrB),
    .irqTc     (irqTc),
    .irqOvr    (irqOvr)
  );

  // Vector: op[40:39] addr[38:36] data[35:20] exp[19:4] req[3:0]
  // op: 0 write, 1 read-check, 2 beat (exp = ack), 3 irq check (exp = {ovr,tc})
  localparam int NV = 37;
  localparam logic [40:0] VEC [NV] = '{
    {2'd0, 3'd2, 16'h0100, 16'h0000, 4'd2},   // R2 working A
    {2'd0, 3'd3, 16'h0200, 16'h0000, 4'd2},   // R2 working B
    {2'd0, 3'd4, 16'h0002, 16'h0000, 4'd2},   // R2 working count
    {2'd0, 3'd0, 16'h001D, 16'h0000, 4'd3},   // R3 enable, indirect, both irq
    {2'd1, 3'd1, 16'h0000, 16'h0008, 4'd3},   // R3 active
    {2'd1, 3'd0, 16'h0000, 16'h001D, 4'd2},   // R2 control readback
    {2'd0, 3'd5, 16'h0300, 16'h0000, 4'd6},   // R6 shadow A
    {2'd0, 3'd6, 16'h0400, 16'h0000, 4'd6},   // R6 shadow B
    {2'd1, 3'd1, 16'h0000, 16'h0008, 4'd6},   // R6 valid not yet set
    {2'd0, 3'd7, 16'h0003, 16'h0000, 4'd6},   // R6 shadow count
    {2'd1, 3'd1, 16'h0000, 16'h0009, 4'd6},   // R6 valid set
    {2'd1, 3'd5, 16'h0000, 16'h0300, 4'd2},   // R2 shadow A readback
    {2'd2, 3'd0, 16'h0000, 16'h0001, 4'd4},   // R4 beat
    {2'd1, 3'd2, 16'h0000, 16'h0101, 4'd4},   // R4 A advanced
    {2'd1, 3'd3, 16'h0000, 16'h0201, 4'd4},   // R4 B advanced (indirect)
    {2'd1, 3'd4, 16'h0000, 16'h0001, 4'd4},   // R4 count down
    {2'd0, 3'd2, 16'h0FFF, 16'h0000, 4'd5},   // R5 write while active
    {2'd1, 3'd2, 16'h0000, 16'h0101, 4'd5},   // R5 ignored
    {2'd2, 3'd0, 16'h0000, 16'h0001, 4'd8},   // R8 last beat, valid set
    {2'd1, 3'd1, 16'h0000, 16'h000A, 4'd8},   // R8 TC+active, valid consumed
    {2'd3, 3'd0, 16'h0000, 16'h0001, 4'd7},   // R7 tc irq
    {2'd1, 3'd2, 16'h0000, 16'h0300, 4'd8},   // R8 A reloaded
    {2'd1, 3'd3, 16'h0000, 16'h0400, 4'd8},   // R8 B reloaded
    {2'd1, 3'd4, 16'h0000, 16'h0003, 4'd8},   // R8 count reloaded
    {2'd2, 3'd0, 16'h0000, 16'h0001, 4'd4},   // R4
    {2'd2, 3'd0, 16'h0000, 16'h0001, 4'd4},   // R4
    {2'd2, 3'd0, 16'h0000, 16'h0001, 4'd9},   // R9 last beat, valid clear
    {2'd1, 3'd1, 16'h0000, 16'h0006, 4'd9},   // R9 TC+OVR, idle
    {2'd3, 3'd0, 16'h0000, 16'h0003, 4'd9},   // R9 both irqs
    {2'd2, 3'd0, 16'h0000, 16'h0000, 4'd9},   // R9 no ack after stop
    {2'd1, 3'd4, 16'h0000, 16'h0000, 4'd9},   // R9 count stays 0
    {2'd1, 3'd2, 16'h0000, 16'h0303, 4'd9},   // R9 A
    {2'd0, 3'd1, 16'h0006, 16'h0000, 4'd13},  // R13 clear flags
    {2'd1, 3'd1, 16'h0000, 16'h0000, 4'd13},  // R13
    {2'd3, 3'd0, 16'h0000, 16'h0000, 4'd13},  // R13 irqs drop
    {2'd0, 3'd0, 16'h0000, 16'h0000, 4'd3},   // R3 write while enabled
    {2'd1, 3'd0, 16'h0000, 16'h001C, 4'd3}    // R3 only enable bit changed
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #1 check(tag, regRdData, exp);
  endtask

  task automatic beat(input logic expAck, input string tag);
    @(negedge clk);
    xferReq = 1'b1;
    #1 check(tag, {15'd0, xferAck}, {15'd0, expAck});
    @(negedge clk);
    xferReq = 1'b0;
  endtask

  // Beat and register write in the same cycle
  task automatic beatWr(input logic [2:0] a, input logic [15:0] d, input string tag);
    @(negedge clk);
    xferReq = 1'b1; regWrEn = 1'b1; regAddr = a; regWrData = d;
    #1 check(tag, {15'd0, xferAck}, 16'd1);
    @(negedge clk);
    xferReq = 1'b0; regWrEn = 1'b0;
  endtask

  task automatic irqChk(input logic [1:0] exp, input string tag);
    @(negedge clk);
    #1 check(tag, {14'd0, irqOvr, irqTc}, {14'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 8; a++) rd(3'(a), 16'h0, "R1 register");
    @(negedge clk);
    xferReq = 1'b1;
    #1 check("R1 ack", {15'd0, xferAck}, 16'd0);
    check("R1 irq", {14'd0, irqOvr, irqTc}, 16'd0);
    xferReq = 1'b0;

    // Double-buffer sequence from the vector table
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [2:0]  a;
      logic [15:0] d, e;
      string tag;
      op = VEC[i][40:39]; a = VEC[i][38:36];
      d  = VEC[i][35:20]; e = VEC[i][19:4];
      tag = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
      case (op)
        2'd0: wr(a, d);
        2'd1: rd(a, e, tag);
        2'd2: beat(e[0], tag);
        default: irqChk(e[1:0], tag);
      endcase
    end

    // R10 / R11: auto-initialize in flyby mode
    wr(3'd2, 16'h0010); wr(3'd3, 16'h0020); wr(3'd4, 16'h0001);
    wr(3'd5, 16'h0010); wr(3'd6, 16'h0050); wr(3'd7, 16'h0001);
    wr(3'd1, 16'h0001);
    rd(3'd1, 16'h0000, "R6 valid write-1-clear");
    wr(3'd0, 16'h0003);
    rd(3'd1, 16'h0008, "R3 enable sets active");
    beat(1'b1, "R10 beat");
    rd(3'd1, 16'h000A, "R10 no overrun, still active");
    rd(3'd3, 16'h0020, "R11 B not copied");
    rd(3'd4, 16'h0001, "R10 count reloaded");
    irqChk(2'b00, "R7 tc irq masked");
    wr(3'd0, 16'h0007);
    rd(3'd0, 16'h0003, "R3 bits ignored while enabled");
    beat(1'b1, "R10 second block");
    rd(3'd2, 16'h0010, "R10 same region");
    wr(3'd0, 16'h0000);
    rd(3'd1, 16'h0002, "R3 disable clears active");
    beat(1'b0, "R3 no ack when disabled");

    // R12: late shadow-count write, old valid clear
    wr(3'd1, 16'h0007);
    wr(3'd2, 16'h0080); wr(3'd4, 16'h0001);
    wr(3'd0, 16'h0001);
    beatWr(3'd7, 16'h0005, "R12 last beat ack");
    rd(3'd1, 16'h0007, "R12 overrun despite write, valid set");
    rd(3'd4, 16'h0000, "R12 count stays 0");

    // R13: TC set wins over same-cycle clear; chain with valid
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0007);
    wr(3'd4, 16'h0001); wr(3'd7, 16'h0002);
    wr(3'd0, 16'h0001);
    beatWr(3'd1, 16'h0002, "R13 last beat ack");
    rd(3'd1, 16'h000A, "R13 TC kept, R8 chained");
    rd(3'd4, 16'h0002, "R8 count reloaded");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule